// File: doc/BRIEF.md
# Saturating Signed Arithmetic Unit with Sticky Saturation Flag

This block is a 32-bit signed arithmetic unit for a processor datapath. It performs four operations. Two are plain saturating add and subtract. The other two first double the second operand, then add it to or subtract it from the first operand. When a true result cannot be represented, the output is clamped to the most positive or most negative word and does not wrap.

A doubling operation can saturate twice: once when the second operand is doubled, and again when that doubled value is combined with the first operand. Either event counts as saturation. Every saturation event raises a one-cycle pulse and sets a sticky flag. Arithmetic can set the sticky flag but can never clear it. The flag goes low only on an explicit clear request. The result and the pulse are registered, so they appear one clock after the operation is presented with its valid strobe.

Top module: `satalu`

## Requirements
- R1: With `inValid` high and `opSel` = 2'b00, `result` on the next cycle equals the saturated signed sum `opA + opB`.
- R2: With `inValid` high and `opSel` = 2'b01, `result` on the next cycle equals the saturated signed difference `opA - opB`.
- R3: With `inValid` high and `opSel` = 2'b10, `result` on the next cycle equals `sat(opA + sat(2*opB))`.
- R4: With `inValid` high and `opSel` = 2'b11, `result` on the next cycle equals `sat(opA - sat(2*opB))`.
- R5: Saturation clamps a positive overflow to 32'h7FFFFFFF and a negative overflow to 32'h80000000.
- R6: `satPulse` is high for exactly the one cycle after a valid operation in which either saturation step occurred, and is low otherwise.
- R7: `satFlag` goes high the cycle after any saturation event and stays high through later non-saturating operations.
- R8: `flagClear` drives `satFlag` low on the next cycle, unless a saturating valid operation occurs in the same cycle, in which case `satFlag` is high.
- R9: While `rstN` is low, `result`, `satPulse` and `satFlag` are all zero.
- R10: With `inValid` low, `result` keeps its previous value and `satPulse` stays low, whatever the operand and opcode inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | An operation is presented this cycle |
| opSel | input | 2 | Operation select: 00 add, 01 sub, 10 doubling add, 11 doubling sub |
| opA | input | 32 | First signed operand |
| opB | input | 32 | Second signed operand (the one that is doubled) |
| flagClear | input | 1 | Request to clear the sticky flag |
| result | output | 32 | Registered saturated result |
| satPulse | output | 1 | One-cycle pulse: the last operation saturated |
| satFlag | output | 1 | Sticky saturation flag |

## Verification
All three outputs are due one clock edge after the cycle in which the operation or clear request is presented. The bench drives the inputs on the falling edge and lets exactly one rising edge capture them. It then samples `result`, `satPulse` and `satFlag` on the following falling edge, when all three reflect that one operation. Idle cycles are checked the same way, one edge after `inValid` is dropped, so hold and clear behaviour is observed before any further stimulus arrives.

// File: rtl/satalu_pkg.sv
package satalu_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DADD = 2'b10,
    OP_DSUB = 2'b11
  } opCode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // register a new result this cycle
    logic subtract;  // second step subtracts instead of adds
    logic doubleB;   // second operand goes through the doubling stage
  } strobe_t;

endpackage

// File: rtl/satalu_ctrl.sv
module satalu_ctrl
  import satalu_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic [1:0] opSel,
  input  logic    flagClear,
  input  logic    satHit,
  output strobe_t stb,
  output logic    satFlag
);

  opCode_t op;

  always_comb begin
    op          = opCode_t'(opSel);
    stb.capture = inValid;
    stb.subtract = (op == OP_SUB) || (op == OP_DSUB);
    stb.doubleB  = (op == OP_DADD) || (op == OP_DSUB);
  end

  // a set from arithmetic outranks a clear request in the same cycle
  logic flagNext;
  always_comb begin
    flagNext = flagClear ? 1'b0 : satFlag;
    if (inValid && satHit) flagNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) satFlag <= 1'b0;
    else       satFlag <= flagNext;
  end

endmodule

// File: rtl/satalu_dp.sv
module satalu_dp
  import satalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      stb,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         satHit,
  output logic [W-1:0] result,
  output logic         satPulse
);

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic         dblOvf;
  logic [W-1:0] bDbl;
  logic [W-1:0] bSel;
  logic [W:0]   aWide;
  logic [W:0]   bWide;
  logic [W:0]   sumWide;
  logic         sumOvf;
  logic [W-1:0] sumSat;

  always_comb begin
    // doubling overflows when the top two bits disagree
    dblOvf  = stb.doubleB && (opB[W-1] != opB[W-2]);
    bDbl    = (opB[W-1] != opB[W-2]) ? (opB[W-1] ? MINV : MAXV)
                                     : {opB[W-2:0], 1'b0};
    bSel    = stb.doubleB ? bDbl : opB;
    aWide   = {opA[W-1], opA};
    bWide   = {bSel[W-1], bSel};
    sumWide = stb.subtract ? (aWide - bWide) : (aWide + bWide);
    // guard bit disagreeing with the sign bit means out of range
    sumOvf  = sumWide[W] != sumWide[W-1];
    sumSat  = sumOvf ? (sumWide[W] ? MINV : MAXV) : sumWide[W-1:0];
    satHit  = dblOvf || sumOvf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      satPulse <= 1'b0;
    end else begin
      satPulse <= stb.capture && satHit;
      if (stb.capture) result <= sumSat;
    end
  end

endmodule

// File: rtl/satalu.sv
module satalu
  import satalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [1:0]   opSel,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  input  logic         flagClear,
  output logic [W-1:0] result,
  output logic         satPulse,
  output logic         satFlag
);

  strobe_t stb;
  logic    satHit;

  satalu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .flagClear(flagClear), .satHit(satHit), .stb(stb), .satFlag(satFlag)
  );

  satalu_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .opA(opA), .opB(opB),
    .satHit(satHit), .result(result), .satPulse(satPulse)
  );

endmodule

// File: rtl/satalu_chk.sv
module satalu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [1:0]   opSel,
  input logic         flagClear,
  input logic [W-1:0] result,
  input logic         satPulse,
  input logic         satFlag
);

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    satPulse |-> satFlag); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag && !flagClear) |=> satFlag); // R7

  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear && !inValid) |=> !satFlag); // R8

  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !satPulse); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result)); // R10

  AST_PLAIN_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opSel[1]) ##1 satPulse |-> (result == MAXV || result == MINV)); // R5

  AST_RESET_ZERO: assert property (@(posedge clk)
    !rstN |-> (result == '0 && !satPulse && !satFlag)); // R9

endmodule

bind satalu satalu_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
  .flagClear(flagClear), .result(result), .satPulse(satPulse),
  .satFlag(satFlag)
);

// File: tb/satalu_test.sv
`timescale 1ns/1ps
module satalu_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        flagClear = 1'b0;
  logic [31:0] result;
  logic        satPulse;
  logic        satFlag;

  int checks = 0;
  int fails = 0;
  logic expFlag = 1'b0;

  always #2.5 clk = ~clk;

  satalu uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .flagClear(flagClear),
    .result(result), .satPulse(satPulse), .satFlag(satFlag)
  );

  localparam longint LMAX = 64'sd2147483647;
  localparam longint LMIN = -64'sd2147483648;

  function automatic longint clampW(input longint x, inout bit hit);
    if (x > LMAX) begin hit = 1; return LMAX; end
    if (x < LMIN) begin hit = 1; return LMIN; end
    return x;
  endfunction

  // reference model: returns result, sets hit on any saturation step
  function automatic logic [31:0] refOp(input logic [1:0] op,
      input logic [31:0] a, input logic [31:0] b, output bit hit);
    longint av, bv, r;
    hit = 0;
    av = longint'($signed(a));
    bv = longint'($signed(b));
    if (op[1]) bv = clampW(2 * bv, hit);
    r = op[0] ? av - bv : av + bv;
    r = clampW(r, hit);
    return r[31:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after capture
  task automatic runOp(input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic clr);
    bit hit;
    logic [31:0] exp;
    string tag;
    exp = refOp(op, a, b, hit);
    inValid = 1'b1; opSel = op; opA = a; opB = b; flagClear = clr;
    @(negedge clk);
    inValid = 1'b0; flagClear = 1'b0;
    expFlag = (expFlag & ~clr) | hit;
    case (op)
      2'b00: tag = "R1";
      2'b01: tag = "R2";
      2'b10: tag = "R3";
      default: tag = "R4";
    endcase
    if (hit) tag = {tag, "/R5"};
    check(tag, result, exp);
    check("R6 pulse", {31'b0, satPulse}, {31'b0, hit});
    check(clr ? "R8 flag" : "R7 flag", {31'b0, satFlag}, {31'b0, expFlag});
  endtask

  logic [31:0] vals [12];

  initial begin
    vals[0] = 32'h00000000; vals[1] = 32'h00000001; vals[2] = 32'hFFFFFFFF;
    vals[3] = 32'h00000002; vals[4] = 32'hFFFFFFFE; vals[5] = 32'h3FFFFFFF;
    vals[6] = 32'h40000000; vals[7] = 32'hC0000000; vals[8] = 32'hBFFFFFFF;
    vals[9] = 32'h7FFFFFFF; vals[10] = 32'h80000000; vals[11] = 32'h12345678;

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 result", result, 32'h0);
    check("R9 pulse", {31'b0, satPulse}, 32'h0);
    check("R9 flag", {31'b0, satFlag}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R5 / R3: doubling step alone saturates, sum fits
    runOp(2'b10, 32'hFFFFFFFF, 32'h40000000, 1'b0);
    check("R3 first-step", result, 32'h7FFFFFFE);

    // R8: clear alone
    flagClear = 1'b1;
    @(negedge clk);
    flagClear = 1'b0;
    expFlag = 1'b0;
    check("R8 clear", {31'b0, satFlag}, 32'h0);

    // R7: non-saturating op keeps the flag clear, saturating op sets it
    runOp(2'b00, 32'h5, 32'h7, 1'b0);
    runOp(2'b01, 32'h80000000, 32'h1, 1'b0);
    check("R5 min", result, 32'h80000000);
    runOp(2'b00, 32'h1, 32'h1, 1'b0);
    check("R7 held", {31'b0, satFlag}, 32'h1);

    // R8: clear together with a saturating op leaves flag set
    runOp(2'b00, 32'h7FFFFFFF, 32'h1, 1'b1);
    check("R8 set wins", {31'b0, satFlag}, 32'h1);
    check("R5 max", result, 32'h7FFFFFFF);

    // R10: idle cycle with changing inputs holds result, no pulse
    runOp(2'b00, 32'h10, 32'h20, 1'b0);
    opSel = 2'b11; opA = 32'h80000000; opB = 32'h7FFFFFFF;
    @(negedge clk);
    check("R10 hold", result, 32'h30);
    check("R10 no pulse", {31'b0, satPulse}, 32'h0);

    // sweep all ops over edge operand pairs, clear mixed in
    for (int o = 0; o < 4; o++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          runOp(o[1:0], vals[i], vals[j], ((i + j + o) % 3) == 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule